// File: doc/BRIEF.md
# Interrupt Message Vector Table

This block holds a table of per-vector interrupt messages and an array of pending bits. Both sit in a 4 KiB memory-mapped window that a host bus reaches with 32-bit reads and writes. Device logic raises one interrupt request line per vector. When a request line rises on an unmasked vector, the block emits a message write: a 64-bit address and 32-bit data, offered on a valid/ready output port.

If the function mask or the vector's own mask blocks the event, the event is recorded as pending. It is replayed later in three cases: a table write to that vector leaves it unmasked, or the capability block asks for a re-check of all vectors, or global enable is restored. The global enable input and the function mask input come from a separate capability register block. That block also drives the re-check request.

Each table entry is 16 bytes wide. Entry n starts at offset n*16. The pending bits start at offset 0x800 and can only be read from the bus.

Top module: `irq_msg_table`

## Requirements
- R1: After reset, every table word and every pending bit reads as zero, and `msg_valid_o` is low.
- R2: Entry n holds four 32-bit words at offset n*16 + 4*w: w=0 address low, w=1 address high, w=2 data, w=3 control. Each word reads back what was last written. Bit 0 of the control word masks the vector when set.
- R3: The pending array is read at offset 0x800. Vector n appears as bit n of that 32-bit word, which is bit n mod 8 of byte 0x800 + n/8. Bus writes at offset 0x800 or above change nothing.
- R4: An access is accepted only when all four byte enables are set and address bits [1:0] are zero. A rejected write changes nothing, and a rejected read returns zero.
- R5: A read of any other offset that no word occupies, such as an entry index at or above the vector count, returns zero.
- R6: Only a rising edge of `irq_i[n]` is an event. Holding the line high produces no further message.
- R7: An event on an unmasked vector, while global enable is set and the function mask is clear, sets `msg_valid_o` on the second clock edge after the edge that sees the rise. The message address is {address high, address low with bits [1:0] cleared}, and the data is the data word. The pending bit clears when the message is issued.
- R8: An event on a vector blocked by its mask bit or by `fn_mask_i` sets the vector's pending bit and sends no message.
- R9: A table write to any word of a pending vector that leaves the vector unmasked sends its message and clears its pending bit.
- R10: A pulse on `rescan_i` delivers every pending, unmasked vector in ascending index order. Clearing `fn_mask_i` alone delivers nothing.
- R11: While `glb_en_i` is low, no message is issued, and an unmasked event stays pending. The event is sent once `glb_en_i` returns high.
- R12: Events that occur together are served lowest index first, one message per accepted handshake. While `msg_ready_i` is low, `msg_valid_o`, `msg_addr_o` and `msg_data_o` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus access strobe, one cycle per access |
| bus_we_i | input | 1 | Set for a write, clear for a read |
| bus_addr_i | input | 12 | Byte offset within the window |
| bus_be_i | input | 4 | Byte enables; all must be set |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, registered one edge after the request |
| irq_i | input | NUM_VEC | Per-vector interrupt request levels |
| glb_en_i | input | 1 | Global message enable |
| fn_mask_i | input | 1 | Function-wide mask |
| rescan_i | input | 1 | Pulse requesting a re-check of all vectors |
| msg_valid_o | output | 1 | Message write offered |
| msg_ready_i | input | 1 | Message write accepted |
| msg_addr_o | output | 64 | Message address |
| msg_data_o | output | 32 | Message data |

## Verification
Read data is due one clock edge after the request edge. A message is due two edges after the edge that registers an interrupt rise, a table write or a rescan pulse. The bench drives and samples at falling edges, so each check falls between the edges that produce the result. Paths with no message are checked over a window of several cycles, and after that window the pending word is read back through the bus. The sweeps cover every vector of the eight-vector default, every word of every entry, and simultaneous events on all vectors while the output is stalled.

// File: rtl/msgtab_pkg.sv
`timescale 1ns/1ps
package msgtab_pkg;
  typedef struct packed {
    logic [31:0] ctrl;
    logic [31:0] data;
    logic [31:0] hi;
    logic [31:0] lo;
  } entry_t;

  localparam logic [1:0] W_LO   = 2'd0;
  localparam logic [1:0] W_HI   = 2'd1;
  localparam logic [1:0] W_DATA = 2'd2;
  localparam logic [1:0] W_CTRL = 2'd3;
endpackage

// File: rtl/msgtab_regs.sv
`timescale 1ns/1ps
module msgtab_regs
  import msgtab_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int VW      = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [6:0]         wr_idx_i,
  input  logic [1:0]         wr_word_i,
  input  logic [31:0]        wr_data_i,
  input  logic [6:0]         rd_idx_i,
  input  logic [1:0]         rd_word_i,
  output logic [31:0]        rd_data_o,
  input  logic [VW-1:0]      sel_idx_i,
  output logic [63:0]        sel_addr_o,
  output logic [31:0]        sel_data_o,
  output logic [NUM_VEC-1:0] vmask_o,
  output logic [NUM_VEC-1:0] wr_hit_o
);
  localparam logic [7:0] NV8 = 8'(NUM_VEC);

  entry_t [NUM_VEC-1:0] tab_q;

  for (genvar n = 0; n < NUM_VEC; n++) begin : g_ent
    assign wr_hit_o[n] = wr_en_i && (wr_idx_i == 7'(n));
    assign vmask_o[n]  = tab_q[n].ctrl[0];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tab_q[n] <= '0;
      end else if (wr_hit_o[n]) begin
        unique case (wr_word_i)
          W_LO:    tab_q[n].lo   <= wr_data_i;
          W_HI:    tab_q[n].hi   <= wr_data_i;
          W_DATA:  tab_q[n].data <= wr_data_i;
          default: tab_q[n].ctrl <= wr_data_i;
        endcase
      end
    end

    // R2
    ctrl_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_hit_o[n] && wr_word_i == W_CTRL) |=> (tab_q[n].ctrl == $past(wr_data_i)));
  end

  always_comb begin
    rd_data_o = '0;
    if ({1'b0, rd_idx_i} < NV8) begin
      unique case (rd_word_i)
        W_LO:    rd_data_o = tab_q[rd_idx_i[VW-1:0]].lo;
        W_HI:    rd_data_o = tab_q[rd_idx_i[VW-1:0]].hi;
        W_DATA:  rd_data_o = tab_q[rd_idx_i[VW-1:0]].data;
        default: rd_data_o = tab_q[rd_idx_i[VW-1:0]].ctrl;
      endcase
    end
  end

  assign sel_addr_o = {tab_q[sel_idx_i].hi, tab_q[sel_idx_i].lo[31:2], 2'b00};
  assign sel_data_o = tab_q[sel_idx_i].data;
endmodule

// File: rtl/msgtab_pend.sv
`timescale 1ns/1ps
module msgtab_pend #(
  parameter int NUM_VEC = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_VEC-1:0] irq_i,
  input  logic [NUM_VEC-1:0] vmask_i,
  input  logic               fn_mask_i,
  input  logic [NUM_VEC-1:0] wr_hit_i,
  input  logic               rescan_i,
  input  logic [NUM_VEC-1:0] clr_i,
  output logic [NUM_VEC-1:0] pend_o,
  output logic [NUM_VEC-1:0] arm_o
);
  logic [NUM_VEC-1:0] irq_q, pend_q, arm_q;
  logic [NUM_VEC-1:0] rise, blocked, pend_d, arm_d;

  assign rise    = irq_i & ~irq_q;
  assign blocked = vmask_i | {NUM_VEC{fn_mask_i}};
  // a new rise wins over the clear of an issued message
  assign pend_d  = (pend_q & ~clr_i) | rise;
  // armed = due for a check; a check that finds the vector blocked disarms it
  assign arm_d   = ((arm_q & ~blocked & ~clr_i) | rise | wr_hit_i
                   | {NUM_VEC{rescan_i}}) & pend_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= '0;
      pend_q <= '0;
      arm_q  <= '0;
    end else begin
      irq_q  <= irq_i;
      pend_q <= pend_d;
      arm_q  <= arm_d;
    end
  end

  assign pend_o = pend_q;
  assign arm_o  = arm_q;

  for (genvar i = 0; i < NUM_VEC; i++) begin : g_chk
    // R6
    rise_sets_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_i[i] && !irq_q[i]) |=> pend_q[i]);
    // R7
    issue_clears_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !rise[i]) |=> !pend_q[i]);
  end
endmodule

// File: rtl/msgtab_pick.sv
`timescale 1ns/1ps
module msgtab_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    any_o = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        gnt_o    = '0;
        gnt_o[i] = 1'b1;
        idx_o    = IW'(i);
        any_o    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_msg_table.sv
`timescale 1ns/1ps
module irq_msg_table #(
  parameter int NUM_VEC = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_req_i,
  input  logic               bus_we_i,
  input  logic [11:0]        bus_addr_i,
  input  logic [3:0]         bus_be_i,
  input  logic [31:0]        bus_wdata_i,
  output logic [31:0]        bus_rdata_o,
  input  logic [NUM_VEC-1:0] irq_i,
  input  logic               glb_en_i,
  input  logic               fn_mask_i,
  input  logic               rescan_i,
  output logic               msg_valid_o,
  input  logic               msg_ready_i,
  output logic [63:0]        msg_addr_o,
  output logic [31:0]        msg_data_o
);
  localparam int VW     = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;
  localparam int PBA_DW = (NUM_VEC + 31) / 32;

  logic               acc_ok, in_pba, wr_en;
  logic [6:0]         ent_idx;
  logic [1:0]         word;
  logic [8:0]         dw;
  logic [31:0]        tab_rd, rd_next;
  logic [VW-1:0]      sel_idx;
  logic [63:0]        sel_addr;
  logic [31:0]        sel_data;
  logic [NUM_VEC-1:0] vmask, wr_hit, pend, arm, cand, gnt, clr;
  logic               any, load;
  logic [PBA_DW*32-1:0] pba_w;

  assign acc_ok  = bus_req_i && (bus_be_i == 4'hF) && (bus_addr_i[1:0] == 2'b00);
  assign in_pba  = bus_addr_i[11];
  assign ent_idx = bus_addr_i[10:4];
  assign word    = bus_addr_i[3:2];
  assign dw      = bus_addr_i[10:2];
  assign wr_en   = acc_ok && bus_we_i && !in_pba;

  msgtab_regs #(.NUM_VEC(NUM_VEC), .VW(VW)) u_regs (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_idx_i(ent_idx), .wr_word_i(word), .wr_data_i(bus_wdata_i),
    .rd_idx_i(ent_idx), .rd_word_i(word), .rd_data_o(tab_rd),
    .sel_idx_i(sel_idx), .sel_addr_o(sel_addr), .sel_data_o(sel_data),
    .vmask_o(vmask), .wr_hit_o(wr_hit)
  );

  msgtab_pend #(.NUM_VEC(NUM_VEC)) u_pend (
    .clk_i, .rst_ni,
    .irq_i, .vmask_i(vmask), .fn_mask_i, .wr_hit_i(wr_hit), .rescan_i,
    .clr_i(clr), .pend_o(pend), .arm_o(arm)
  );

  assign cand = pend & arm & ~vmask & {NUM_VEC{glb_en_i && !fn_mask_i}};

  msgtab_pick #(.N(NUM_VEC), .IW(VW)) u_pick (
    .req_i(cand), .gnt_o(gnt), .idx_o(sel_idx), .any_o(any)
  );

  assign load = any && (!msg_valid_o || msg_ready_i);
  assign clr  = load ? gnt : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msg_valid_o <= 1'b0;
      msg_addr_o  <= '0;
      msg_data_o  <= '0;
    end else if (load) begin
      msg_valid_o <= 1'b1;
      msg_addr_o  <= sel_addr;
      msg_data_o  <= sel_data;
    end else if (msg_ready_i) begin
      msg_valid_o <= 1'b0;
    end
  end

  always_comb begin
    pba_w = '0;
    pba_w[NUM_VEC-1:0] = pend;
  end

  always_comb begin
    rd_next = '0;
    if (acc_ok && !bus_we_i) begin
      if (in_pba) begin
        for (int d = 0; d < PBA_DW; d++)
          if (dw == 9'(d)) rd_next = pba_w[d*32 +: 32];
      end else begin
        rd_next = tab_rd;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      bus_rdata_o <= '0;
    else if (bus_req_i && !bus_we_i)  bus_rdata_o <= rd_next;
  end

  // R12
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && !msg_ready_i) |=> (msg_valid_o && $stable(msg_addr_o) && $stable(msg_data_o)));
  // R12
  one_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(clr));
  // R11
  no_issue_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(msg_valid_o) |-> $past(glb_en_i));
  // R8
  no_issue_fnmask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(msg_valid_o) |-> !$past(fn_mask_i));
endmodule

// File: tb/irq_msg_table_tb.sv
`timescale 1ns/1ps
module irq_msg_table_tb;
  localparam int NV = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic bus_req = 0, bus_we = 0;
  logic [11:0] bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NV-1:0] irq = '0;
  logic glb_en = 0, fn_mask = 0, rescan = 0, msg_ready = 1;
  logic msg_valid;
  logic [63:0] msg_addr;
  logic [31:0] msg_data;

  int checks = 0, errors = 0;
  logic [31:0] m_lo [NV], m_hi [NV], m_dat [NV];

  always #10 clk = ~clk;

  irq_msg_table #(.NUM_VEC(NV)) u_dut (
    .clk_i(clk), .rst_ni,
    .bus_req_i(bus_req), .bus_we_i(bus_we), .bus_addr_i(bus_addr), .bus_be_i(bus_be),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .irq_i(irq), .glb_en_i(glb_en), .fn_mask_i(fn_mask), .rescan_i(rescan),
    .msg_valid_o(msg_valid), .msg_ready_i(msg_ready),
    .msg_addr_o(msg_addr), .msg_data_o(msg_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bwrite(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_req = 0; bus_we = 0;
  endtask

  task automatic bread(input logic [11:0] a, output logic [31:0] d, input logic [3:0] be = 4'hF);
    bus_req = 1; bus_we = 0; bus_addr = a; bus_be = be;
    @(negedge clk);
    bus_req = 0;
    d = bus_rdata;
  endtask

  task automatic rchk(input logic [11:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] d;
    bread(a, d);
    chk(d == exp, tag, 64'(d), 64'(exp));
  endtask

  task automatic pulse(input logic [NV-1:0] m);
    irq = irq | m;
    @(negedge clk);
    irq = irq & ~m;
  endtask

  function automatic logic [63:0] exp_addr(input int v);
    return {m_hi[v], m_lo[v][31:2], 2'b00};
  endfunction

  task automatic expect_msg(input int v, input string tag);
    int n = 0;
    while (!msg_valid && n < 30) begin @(negedge clk); n++; end
    chk(msg_valid, {tag, " valid"}, 64'(msg_valid), 64'd1);
    chk(msg_addr == exp_addr(v), {tag, " addr"}, msg_addr, exp_addr(v));
    chk(msg_data == m_dat[v], {tag, " data"}, 64'(msg_data), 64'(m_dat[v]));
    @(negedge clk);
  endtask

  task automatic expect_none(input int c, input string tag);
    bit seen = 0;
    repeat (c) begin @(negedge clk); if (msg_valid) seen = 1; end
    chk(!seen, tag, 64'(seen), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    // R1: reset state
    chk(!msg_valid, "R1 valid after reset", 64'(msg_valid), 64'd0);
    for (int v = 0; v < NV; v++)
      for (int w = 0; w < 4; w++)
        rchk(12'(v*16 + w*4), 32'd0, "R1 table zero");
    rchk(12'h800, 32'd0, "R1 pending zero");

    // R2: fill and read back every word
    for (int v = 0; v < NV; v++) begin
      m_lo[v]  = 32'hFEE0_0003 | (32'(v) << 8);
      m_hi[v]  = 32'h0000_00A0 + 32'(v);
      m_dat[v] = 32'h0000_4000 + 32'(v);
      bwrite(12'(v*16),     m_lo[v]);
      bwrite(12'(v*16 + 4), m_hi[v]);
      bwrite(12'(v*16 + 8), m_dat[v]);
      bwrite(12'(v*16 + 12), 32'hABC0_0000);
    end
    for (int v = 0; v < NV; v++) begin
      rchk(12'(v*16),      m_lo[v],  "R2 addr low");
      rchk(12'(v*16 + 4),  m_hi[v],  "R2 addr high");
      rchk(12'(v*16 + 8),  m_dat[v], "R2 data");
      rchk(12'(v*16 + 12), 32'hABC0_0000, "R2 control");
      bwrite(12'(v*16 + 12), 32'h0);
    end

    // R5: unused offsets
    rchk(12'(NV*16), 32'd0, "R5 entry past count");
    rchk(12'h7FC, 32'd0, "R5 top of table area");
    rchk(12'h804, 32'd0, "R5 past pending word");

    // R4: partial and misaligned accesses
    bwrite(12'h020, 32'h1234_5678, 4'h7);
    bwrite(12'h022, 32'h1234_5678);
    rchk(12'h020, m_lo[2], "R4 rejected write");
    bread(12'h020, d, 4'h3);
    chk(d == 0, "R4 partial read", 64'(d), 64'd0);

    glb_en = 1;
    // R7: exact timing for vector 0
    irq[0] = 1;
    @(negedge clk);
    chk(!msg_valid, "R7 not yet valid", 64'(msg_valid), 64'd0);
    @(negedge clk);
    chk(msg_valid, "R7 valid on second edge", 64'(msg_valid), 64'd1);
    expect_msg(0, "R7 vec0");
    irq[0] = 0;
    // R7: sweep the rest
    for (int v = 1; v < NV; v++) begin
      pulse(NV'(1) << v);
      expect_msg(v, "R7 sweep");
    end
    rchk(12'h800, 32'd0, "R7 pending cleared");

    // R8 vector mask, R3 read-only pending, R9 replay on write
    bwrite(12'h03C, 32'h1);
    pulse(8'h08);
    expect_none(8, "R8 vector masked");
    rchk(12'h800, 32'h08, "R8 pending set");
    bwrite(12'h800, 32'h0);
    bwrite(12'h800, 32'hFF);
    bwrite(12'h804, 32'hFF);
    rchk(12'h800, 32'h08, "R3 pending read-only");
    bwrite(12'h03C, 32'h0);
    expect_msg(3, "R9 replay on unmask");
    rchk(12'h800, 32'd0, "R9 pending cleared");

    // R10: function mask then rescan
    fn_mask = 1;
    pulse(8'h22);
    expect_none(8, "R8 function masked");
    rchk(12'h800, 32'h22, "R8 pending from function mask");
    fn_mask = 0;
    expect_none(8, "R10 unmask alone silent");
    rescan = 1;
    @(negedge clk);
    rescan = 0;
    expect_msg(1, "R10 rescan first");
    expect_msg(5, "R10 rescan second");
    rchk(12'h800, 32'd0, "R10 pending cleared");

    // R11: global enable off
    glb_en = 0;
    pulse(8'h10);
    expect_none(8, "R11 disabled silent");
    rchk(12'h800, 32'h10, "R11 kept pending");
    glb_en = 1;
    expect_msg(4, "R11 sent on enable");

    // R6: held level
    irq[6] = 1;
    expect_msg(6, "R6 first edge");
    expect_none(8, "R6 held level silent");
    irq[6] = 0;
    @(negedge clk);

    // R12: simultaneous events with stalled output
    msg_ready = 0;
    pulse(8'hFF);
    repeat (3) begin
      @(negedge clk);
      chk(msg_valid && msg_addr == exp_addr(0), "R12 stall holds vec0", msg_addr, exp_addr(0));
    end
    msg_ready = 1;
    for (int v = 0; v < NV; v++) expect_msg(v, "R12 ascending");
    expect_none(4, "R12 drained");
    rchk(12'h800, 32'd0, "R12 pending empty");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule